// File: doc/BRIEF.md
# 64-bit Integer Execute Unit

This block is the integer arithmetic and logic stage of a 64-bit load/store processor pipeline. Each issued operation presents two 64-bit register operands, a 16-bit immediate, a 5-bit shift amount, a destination register index and an operation code. One clock later the block presents a 64-bit result, the destination index and a write-enable for the register file write-back port.

The unit covers wrapping add and subtract, the four bitwise logical operations, three constant shifts, signed and unsigned set-less-than, set-equal and set-not-equal (each compare also in an immediate form), load-upper-immediate, and two conditional moves. Compares write the value 0 or 1 rather than setting flags. Because register 0 reads as zero, adding an immediate or a register to it gives load-constant and register move without extra operations.

Output timing is held by a two-state machine. `ST_EMPTY` means no result is presented. `ST_FULL` means a result is presented. The transition `ST_EMPTY -> ST_FULL` and the self-loop `ST_FULL -> ST_FULL` happen on a clock edge where `in_valid` is high. The transition `ST_FULL -> ST_EMPTY` and the self-loop `ST_EMPTY -> ST_EMPTY` happen on an edge where `in_valid` is low. Reset forces `ST_EMPTY`.

Top module: `exu_core`

## Requirements
- R1: While `rst_n` is low, and after its release until the first operation is issued, `out_valid` and `out_wen` are 0 and `out_result` is 0.
- R2: An operation accepted on a clock edge with `in_valid` high produces `out_valid`=1 on the next edge, carrying its `out_dst`. After an edge with `in_valid` low, `out_valid` is 0.
- R3: ADD (code 0), ADDI (1) and SUB (2) compute a+b, a+imm and a-b modulo 2^64, with no overflow indication.
- R4: Every immediate form uses the 16-bit immediate sign-extended to 64 bits. The immediate forms are ADDI (1), ANDI (4), ORI (6), XORI (8), SLTI (14), SLTIU (16), SEQI (18) and SNEI (20).
- R5: AND (3), OR (5), XOR (7) and NOR (9) give the bitwise result of `src_a` and `src_b`.
- R6: SLL (10), SRL (11) and SRA (12) shift `src_a` by `shamt` (0..31). SLL and SRL fill with zeros; SRA fills with the sign bit.
- R7: SLT (13) and SLTI compare as signed two's complement. SLTU (15) and SLTIU compare as unsigned. Each writes 1 when the first operand is less than the second and 0 otherwise.
- R8: SEQ (17) and SEQI write 1 when the operands are equal and 0 otherwise. SNE (19) and SNEI write the inverse.
- R9: LUI (21) produces 32 zero bits, then `imm`, then 16 zero bits, so `imm` lands in bits 31..16.
- R10: MOVZ (22) and MOVN (23) present `src_a` as the result. `out_wen` is 1 only when `src_b` is zero (MOVZ) or nonzero (MOVN); otherwise the destination is left unchanged.
- R11: `out_wen` is 0 whenever `out_dst` is 0. For undefined codes 24..31, `out_wen` is 0 and `out_result` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation issued this cycle |
| in_op | input | 5 | Operation code |
| src_a | input | 64 | First register operand |
| src_b | input | 64 | Second register operand / conditional-move test register |
| imm | input | 16 | Immediate field |
| shamt | input | 5 | Constant shift amount |
| dst | input | 5 | Destination register index |
| out_valid | output | 1 | Result presented |
| out_result | output | 64 | Result for write-back |
| out_wen | output | 1 | Register-file write enable |
| out_dst | output | 5 | Destination register index of the result |

## Verification
Operands that straddle the wrap point (all ones plus one, zero minus one) show whether add and subtract are modular. An all-ones operand compared against one gives opposite answers for the signed and unsigned compares, which separates the two. Immediates with bit 15 set distinguish sign extension from zero extension in every immediate form. Shifts of a negative value by 0 and 31 separate logical from arithmetic fill. Conditional moves are tried with zero and nonzero test registers, and with destination 0, so the write-enable gating is seen apart from the result value. Back-to-back issues with idle gaps between them confirm that each result appears exactly one cycle after its issue.

// File: rtl/exu_pkg.sv
package exu_pkg;
    typedef enum logic [4:0] {
        OP_ADD   = 5'd0,
        OP_ADDI  = 5'd1,
        OP_SUB   = 5'd2,
        OP_AND   = 5'd3,
        OP_ANDI  = 5'd4,
        OP_OR    = 5'd5,
        OP_ORI   = 5'd6,
        OP_XOR   = 5'd7,
        OP_XORI  = 5'd8,
        OP_NOR   = 5'd9,
        OP_SLL   = 5'd10,
        OP_SRL   = 5'd11,
        OP_SRA   = 5'd12,
        OP_SLT   = 5'd13,
        OP_SLTI  = 5'd14,
        OP_SLTU  = 5'd15,
        OP_SLTIU = 5'd16,
        OP_SEQ   = 5'd17,
        OP_SEQI  = 5'd18,
        OP_SNE   = 5'd19,
        OP_SNEI  = 5'd20,
        OP_LUI   = 5'd21,
        OP_MOVZ  = 5'd22,
        OP_MOVN  = 5'd23
    } exu_op_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } stage_e;

    function automatic logic op_uses_imm(input logic [4:0] code);
        case (code)
            5'd1, 5'd4, 5'd6, 5'd8, 5'd14, 5'd16, 5'd18, 5'd20: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/exu_operand_sel.sv
module exu_operand_sel
    import exu_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int IMMW = 16
) (
    input  logic [4:0]      op,
    input  logic [XLEN-1:0] reg_b,
    input  logic [IMMW-1:0] imm,
    output logic [XLEN-1:0] opnd_b
);
    localparam int EXTW = XLEN - IMMW;

    logic [XLEN-1:0] imm_sx;

    always_comb begin
        imm_sx = {{EXTW{imm[IMMW-1]}}, imm};
        opnd_b = op_uses_imm(op) ? imm_sx : reg_b;
    end
endmodule

// File: rtl/exu_arith.sv
module exu_arith
    import exu_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [4:0]      op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] res,
    output logic            hit,
    output logic            is_cmp
);
    logic [XLEN-1:0] sum;
    logic [XLEN-1:0] diff;
    logic            lt_s;
    logic            lt_u;
    logic            eq;
    logic            flag;
    exu_op_e         op_e;

    always_comb begin
        op_e   = exu_op_e'(op);
        sum    = a + b;
        diff   = a - b;
        lt_s   = $signed(a) < $signed(b);
        lt_u   = a < b;
        eq     = (a == b);
        res    = '0;
        flag   = 1'b0;
        hit    = 1'b1;
        is_cmp = 1'b0;
        case (op_e)
            OP_ADD, OP_ADDI: res = sum;
            OP_SUB:          res = diff;
            OP_AND, OP_ANDI: res = a & b;
            OP_OR,  OP_ORI:  res = a | b;
            OP_XOR, OP_XORI: res = a ^ b;
            OP_NOR:          res = ~(a | b);
            OP_SLT, OP_SLTI: begin flag = lt_s; is_cmp = 1'b1; end
            OP_SLTU, OP_SLTIU: begin flag = lt_u; is_cmp = 1'b1; end
            OP_SEQ, OP_SEQI: begin flag = eq;   is_cmp = 1'b1; end
            OP_SNE, OP_SNEI: begin flag = !eq;  is_cmp = 1'b1; end
            default:         hit = 1'b0;
        endcase
        if (is_cmp) res = {{(XLEN-1){1'b0}}, flag};
    end
endmodule

// File: rtl/exu_shift.sv
module exu_shift
    import exu_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int SHW  = 5
) (
    input  logic [4:0]      op,
    input  logic [XLEN-1:0] a,
    input  logic [SHW-1:0]  shamt,
    output logic [XLEN-1:0] res,
    output logic            hit
);
    exu_op_e op_e;

    always_comb begin
        op_e = exu_op_e'(op);
        res  = '0;
        hit  = 1'b1;
        case (op_e)
            OP_SLL:  res = a << shamt;
            OP_SRL:  res = a >> shamt;
            OP_SRA:  res = $unsigned($signed(a) >>> shamt);
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/exu_core.sv
module exu_core
    import exu_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int IMMW = 16,
    parameter int SHW  = 5,
    parameter int RIDX = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [4:0]      in_op,
    input  logic [XLEN-1:0] src_a,
    input  logic [XLEN-1:0] src_b,
    input  logic [IMMW-1:0] imm,
    input  logic [SHW-1:0]  shamt,
    input  logic [RIDX-1:0] dst,
    output logic            out_valid,
    output logic [XLEN-1:0] out_result,
    output logic            out_wen,
    output logic [RIDX-1:0] out_dst
);
    localparam int LUI_LO = 16;
    localparam int LUI_HI = XLEN - LUI_LO - IMMW;

    logic [XLEN-1:0] opnd_b;
    logic [XLEN-1:0] alu_res;
    logic            alu_hit;
    logic            alu_cmp;
    logic [XLEN-1:0] sh_res;
    logic            sh_hit;
    logic [XLEN-1:0] res_d;
    logic            wen_d;
    logic            lui_d;
    exu_op_e         op_e;

    stage_e          state_q, state_d;
    logic [XLEN-1:0] res_q;
    logic            wen_q;
    logic [RIDX-1:0] dst_q;
    logic            cmp_q;
    logic            lui_q;

    exu_operand_sel #(.XLEN(XLEN), .IMMW(IMMW)) u_opsel (
        .op(in_op), .reg_b(src_b), .imm(imm), .opnd_b(opnd_b)
    );

    exu_arith #(.XLEN(XLEN)) u_arith (
        .op(in_op), .a(src_a), .b(opnd_b),
        .res(alu_res), .hit(alu_hit), .is_cmp(alu_cmp)
    );

    exu_shift #(.XLEN(XLEN), .SHW(SHW)) u_shift (
        .op(in_op), .a(src_a), .shamt(shamt), .res(sh_res), .hit(sh_hit)
    );

    // Result select and write-enable decision
    always_comb begin
        op_e  = exu_op_e'(in_op);
        res_d = '0;
        wen_d = 1'b0;
        lui_d = 1'b0;
        if (alu_hit) begin
            res_d = alu_res;
            wen_d = 1'b1;
        end else if (sh_hit) begin
            res_d = sh_res;
            wen_d = 1'b1;
        end else begin
            case (op_e)
                OP_LUI: begin
                    res_d = {{LUI_HI{1'b0}}, imm, {LUI_LO{1'b0}}};
                    wen_d = 1'b1;
                    lui_d = 1'b1;
                end
                OP_MOVZ: begin
                    res_d = src_a;
                    wen_d = (src_b == '0);
                end
                OP_MOVN: begin
                    res_d = src_a;
                    wen_d = (src_b != '0);
                end
                default: begin
                    res_d = '0;
                    wen_d = 1'b0;
                end
            endcase
        end
        if (dst == '0) wen_d = 1'b0;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: state_d = in_valid ? ST_FULL : ST_EMPTY;
            ST_FULL:  state_d = in_valid ? ST_FULL : ST_EMPTY;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // Result register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
            wen_q <= 1'b0;
            dst_q <= '0;
            cmp_q <= 1'b0;
            lui_q <= 1'b0;
        end else if (in_valid) begin
            res_q <= res_d;
            wen_q <= wen_d;
            dst_q <= dst;
            cmp_q <= alu_cmp;
            lui_q <= lui_d;
        end
    end

    // Outputs driven from state
    always_comb begin
        out_valid  = (state_q == ST_FULL);
        out_result = res_q;
        out_dst    = dst_q;
        out_wen    = (state_q == ST_FULL) && wen_q;
    end

    a_r1_wen_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_wen |-> out_valid);

    a_r2_issue_to_valid: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r2_idle_to_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    a_r11_no_zero_dst_write: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_dst == '0) |-> !out_wen);

    a_r7_cmp_is_bool: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && cmp_q) |-> (out_result[XLEN-1:1] == '0));

    a_r9_lui_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && lui_q) |-> (out_result[LUI_LO-1:0] == '0 &&
                                   out_result[XLEN-1:LUI_LO+IMMW] == '0));
endmodule

// File: tb/test_exu_core.sv
`timescale 1ns/1ps
module test_exu_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [4:0]  in_op = '0;
    logic [63:0] src_a = '0;
    logic [63:0] src_b = '0;
    logic [15:0] imm = '0;
    logic [4:0]  shamt = '0;
    logic [4:0]  dst = '0;
    logic        out_valid;
    logic [63:0] out_result;
    logic        out_wen;
    logic [4:0]  out_dst;

    int n_tests = 0;
    int n_fail  = 0;
    int n_issued = 0;
    int n_seen   = 0;
    bit done = 1'b0;

    typedef struct {
        string       tag;
        logic [63:0] res;
        logic        wen;
        logic [4:0]  dst;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;

    exu_core i_exu_core (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .src_a(src_a), .src_b(src_b), .imm(imm), .shamt(shamt), .dst(dst),
        .out_valid(out_valid), .out_result(out_result), .out_wen(out_wen),
        .out_dst(out_dst)
    );

    function automatic logic [63:0] sx(input logic [15:0] v);
        return {{48{v[15]}}, v};
    endfunction

    function automatic exp_t model(input string tag, input logic [4:0] op,
                                   input logic [63:0] a, input logic [63:0] b,
                                   input logic [15:0] im, input logic [4:0] sh,
                                   input logic [4:0] d);
        exp_t e;
        logic [63:0] bi;
        logic w;
        bi = sx(im);
        w  = 1'b1;
        e.res = '0;
        case (op)
            5'd0:  e.res = a + b;
            5'd1:  e.res = a + bi;
            5'd2:  e.res = a - b;
            5'd3:  e.res = a & b;
            5'd4:  e.res = a & bi;
            5'd5:  e.res = a | b;
            5'd6:  e.res = a | bi;
            5'd7:  e.res = a ^ b;
            5'd8:  e.res = a ^ bi;
            5'd9:  e.res = ~(a | b);
            5'd10: e.res = a << sh;
            5'd11: e.res = a >> sh;
            5'd12: e.res = $unsigned($signed(a) >>> sh);
            5'd13: e.res = {63'b0, $signed(a) < $signed(b)};
            5'd14: e.res = {63'b0, $signed(a) < $signed(bi)};
            5'd15: e.res = {63'b0, a < b};
            5'd16: e.res = {63'b0, a < bi};
            5'd17: e.res = {63'b0, a == b};
            5'd18: e.res = {63'b0, a == bi};
            5'd19: e.res = {63'b0, a != b};
            5'd20: e.res = {63'b0, a != bi};
            5'd21: e.res = {32'b0, im, 16'b0};
            5'd22: begin e.res = a; w = (b == 0); end
            5'd23: begin e.res = a; w = (b != 0); end
            default: begin e.res = '0; w = 1'b0; end
        endcase
        e.tag = tag;
        e.wen = w && (d != 0);
        e.dst = d;
        return e;
    endfunction

    task automatic check(input string tag, input logic ok, input logic [63:0] act,
                         input logic [63:0] expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic issue(input string tag, input logic [4:0] op,
                         input logic [63:0] a, input logic [63:0] b,
                         input logic [15:0] im, input logic [4:0] sh,
                         input logic [4:0] d);
        @(negedge clk);
        in_valid = 1'b1;
        in_op = op; src_a = a; src_b = b; imm = im; shamt = sh; dst = d;
        sb.push_back(model(tag, op, a, b, im, sh, d));
        n_issued++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_op = 5'd31; src_a = '1; src_b = '1; dst = 5'd9;
        end
    endtask

    // Monitor: pops the scoreboard as results appear
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rst_n && out_valid) begin
                n_seen++;
                if (sb.size() == 0) begin
                    check("R2 unexpected result", 1'b0, out_result, 64'h0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check({e.tag, " result"}, out_result === e.res, out_result, e.res);
                    check({e.tag, " wen"}, out_wen === e.wen, {63'b0, out_wen}, {63'b0, e.wen});
                    check({e.tag, " dst (R2)"}, out_dst === e.dst, {59'b0, out_dst}, {59'b0, e.dst});
                end
            end
        end
    end

    // Watchdog
    initial begin
        for (int c = 0; c < 20000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            check("watchdog expired", 1'b0, 64'h0, 64'h1);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset valid", out_valid === 1'b0, {63'b0, out_valid}, 64'h0);
        check("R1 reset wen", out_wen === 1'b0, {63'b0, out_wen}, 64'h0);
        check("R1 reset result", out_result === 64'h0, out_result, 64'h0);
        rst_n = 1'b1;
        idle(2);
        #1;
        check("R1 after release valid", out_valid === 1'b0, {63'b0, out_valid}, 64'h0);

        // R3 wrap-around arithmetic
        issue("R3 add wrap", 5'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 16'h0, 5'd0, 5'd3);
        issue("R3 sub wrap", 5'd2, 64'h0, 64'h1, 16'h0, 5'd0, 5'd4);
        issue("R3 add", 5'd0, 64'h0123_4567_89AB_CDEF, 64'h1111_1111_1111_1111, 16'h0, 5'd0, 5'd5);
        idle(1);
        // R4 sign-extended immediates
        issue("R4 addi neg", 5'd1, 64'h10, 64'h0, 16'hFFFF, 5'd0, 5'd6);
        issue("R4 load constant", 5'd1, 64'h0, 64'hDEAD, 16'h7FFF, 5'd0, 5'd7);
        issue("R4 andi", 5'd4, 64'hF0F0_F0F0_F0F0_F0F0, 64'h0, 16'h8001, 5'd0, 5'd8);
        issue("R4 ori", 5'd6, 64'h0, 64'h0, 16'h8000, 5'd0, 5'd9);
        issue("R4 xori", 5'd8, 64'hAAAA_AAAA_AAAA_AAAA, 64'h0, 16'hFFFF, 5'd0, 5'd10);
        idle(2);
        // R5 logical
        issue("R5 and", 5'd3, 64'hFF00_FF00_1234_5678, 64'h0FF0_0FF0_FFFF_0000, 16'h0, 5'd0, 5'd11);
        issue("R5 or", 5'd5, 64'hFF00_0000_0000_0001, 64'h00FF_0000_0000_0010, 16'h0, 5'd0, 5'd12);
        issue("R5 xor", 5'd7, 64'h5555_5555_5555_5555, 64'hFFFF_0000_FFFF_0000, 16'h0, 5'd0, 5'd13);
        issue("R5 nor / move", 5'd9, 64'h0, 64'h0, 16'h0, 5'd0, 5'd14);
        // R6 shifts
        issue("R6 sll 31", 5'd10, 64'h8000_0000_0000_0003, 64'h0, 16'h0, 5'd31, 5'd15);
        issue("R6 sll 0", 5'd10, 64'h8000_0000_0000_0003, 64'h0, 16'h0, 5'd0, 5'd16);
        issue("R6 srl", 5'd11, 64'h8000_0000_0000_0000, 64'h0, 16'h0, 5'd31, 5'd17);
        issue("R6 sra", 5'd12, 64'h8000_0000_0000_0000, 64'h0, 16'h0, 5'd31, 5'd18);
        idle(1);
        // R7 compares
        issue("R7 slt signed", 5'd13, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 16'h0, 5'd0, 5'd19);
        issue("R7 sltu unsigned", 5'd15, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 16'h0, 5'd0, 5'd20);
        issue("R7 slti", 5'd14, 64'h5, 64'h0, 16'hFFFE, 5'd0, 5'd21);
        issue("R7 sltiu", 5'd16, 64'h5, 64'h0, 16'hFFFE, 5'd0, 5'd22);
        issue("R7 slt equal", 5'd13, 64'h7, 64'h7, 16'h0, 5'd0, 5'd23);
        // R8 equality
        issue("R8 seq eq", 5'd17, 64'h1234, 64'h1234, 16'h0, 5'd0, 5'd24);
        issue("R8 seq ne", 5'd17, 64'h1234, 64'h1235, 16'h0, 5'd0, 5'd25);
        issue("R8 sne", 5'd19, 64'h1234, 64'h1235, 16'h0, 5'd0, 5'd26);
        issue("R8 seqi neg", 5'd18, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 16'hFFFF, 5'd0, 5'd27);
        issue("R8 snei", 5'd20, 64'h3, 64'h0, 16'h3, 5'd0, 5'd28);
        idle(2);
        // R9 load upper immediate
        issue("R9 lui", 5'd21, 64'hFFFF, 64'hFFFF, 16'h8001, 5'd0, 5'd29);
        // R10 conditional moves
        issue("R10 movz taken", 5'd22, 64'hCAFE, 64'h0, 16'h0, 5'd0, 5'd30);
        issue("R10 movz kept", 5'd22, 64'hCAFE, 64'h8, 16'h0, 5'd0, 5'd30);
        issue("R10 movn taken", 5'd23, 64'hBEEF, 64'h8, 16'h0, 5'd0, 5'd31);
        issue("R10 movn kept", 5'd23, 64'hBEEF, 64'h0, 16'h0, 5'd0, 5'd31);
        // R11 register 0 and undefined codes
        issue("R11 add to r0", 5'd0, 64'h5, 64'h6, 16'h0, 5'd0, 5'd0);
        issue("R11 undefined 24", 5'd24, 64'h5, 64'h6, 16'h1, 5'd1, 5'd2);
        issue("R11 undefined 31", 5'd31, 64'hFF, 64'hFF, 16'h1, 5'd1, 5'd2);
        idle(1);
        #1;
        check("R2 idle gap", out_valid === 1'b1, {63'b0, out_valid}, 64'h1);
        idle(1);
        #1;
        check("R2 empty after idle", out_valid === 1'b0, {63'b0, out_valid}, 64'h0);

        // Back-to-back burst over all codes
        for (int k = 0; k < 64; k++) begin
            logic [63:0] va;
            logic [63:0] vb;
            va = {32'h9E37_79B9 * k, 32'h7F4A_7C15 ^ k};
            vb = (k % 5 == 0) ? 64'h0 : {32'h8516_2AB1 + k, 32'hC2B2_AE35 * k};
            issue("R3 R5 R6 R7 burst", k[4:0], va, vb, k[15:0] * 16'h1357,
                  k[4:0], k[4:0] ^ 5'd7);
        end
        idle(3);
        check("R2 all results seen", n_seen == n_issued, 64'(n_seen), 64'(n_issued));
        check("R2 scoreboard empty", sb.size() == 0, 64'(sb.size()), 64'h0);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule